// File: doc/BRIEF.md
# Command-Packet ATA Register Sequencer

This block executes one command packet that already sits in a local byte buffer. It reads the 16-byte packet header, then replays the packet's ATA register writes onto a taskfile write port. That port carries a register index, a data byte and a write strobe. The buffer is read through a 16-bit combinational port, one byte pair per cycle, so each register entry is consumed in a single cycle.

Each register entry is a pair: a value byte followed by an address byte. The address byte carries the register index and two flags. One flag drops the pair without a write. The other flag ends the list. The packet length is given in 8-byte units with an offset of two, and it bounds how far the walk may go. When the packet's data flag is set, the block hands the descriptor pointer to a separate descriptor walker and waits for that walker to finish. Finally it produces a response byte for header byte 0 that reports done, a device error or a packet format error, and it raises an interrupt pulse if the packet asked for one.

Top module: `pkt_reg_sequencer`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. `busy` rises in the cycle after the accepting edge and stays high up to and including the cycle in which `respWe` is high. It is low in the next cycle. A `start` seen while `busy` is high has no effect.
- R2: The header is read as 16-bit words, with byte 2k on bits 7:0 and byte 2k+1 on bits 15:8. Byte 2 holds the flags and byte 3 the length. `nextPtr` shows bytes 4 to 7 as a little-endian value. `descPtr` shows bytes 8 to 11 as a little-endian value. Both outputs are stable from the cycle of the response onward.
- R3: The valid flag is flags bit 0. If it is clear, no taskfile write occurs, and the response is a format error in the fifth cycle after the start edge.
- R4: Register pairs start at byte 16, value byte first, and are handled in buffer order at one per cycle. Pair p is handled at edge 6+p after the start edge. A write drives `tfAddr` with address bits 4:0 and `tfData` with the value byte, with `tfWe` high for that one cycle.
- R5: An address byte with bit 5 set produces no write, but the pair still uses its slot.
- R6: An address byte with bit 7 set is the last pair. No later pair is read. Without a data phase, the response appears in the same cycle as that pair's write slot.
- R7: The walk is allowed 4 × length pairs, capped at the pairs the buffer can hold. If the limit is reached before a last pair, the block gives a format-error response one cycle later and makes no further writes. A length of zero gives a format-error response at cycle 6.
- R8: With flags bit 2 set, `descStart` pulses for one cycle in the cycle of the last pair's slot. The response follows in the cycle after the edge that samples `dataDone` high.
- R9: `respWe` is high for exactly one cycle. `respByte` takes one of three values. It is 0x02 (format error) for an invalid, zero-length or overrun packet. Otherwise it is 0x08 if `devErr` is high in that cycle. Otherwise it is 0x01 (done).
- R10: `irq` is high exactly in the response cycle, and only if flags bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing the packet in the buffer |
| bufAddr | output | 7 | Word index into the packet buffer |
| bufData | input | 16 | Buffer word, combinational read of `bufAddr` |
| tfWe | output | 1 | Taskfile write strobe |
| tfAddr | output | 5 | Taskfile register index |
| tfData | output | 8 | Taskfile write data |
| descStart | output | 1 | Start pulse for the descriptor walker |
| descPtr | output | 32 | Descriptor pointer from the header |
| nextPtr | output | 32 | Next-packet pointer from the header |
| dataDone | input | 1 | Descriptor walker finished the data phase |
| devErr | input | 1 | Device reports an error, sampled in the response cycle |
| respWe | output | 1 | Response byte write strobe |
| respByte | output | 8 | Response byte for header byte 0 |
| irq | output | 1 | Completion interrupt pulse |
| busy | output | 1 | Packet in progress |

## Verification
The assertions assume a few things about the inputs:
- `start` arrives as an isolated pulse.
- `dataDone` is raised only while the block waits after `descStart`.
- The buffer contents do not change while `busy` is high.

The stimulus writes each packet into the bench's buffer model before pulsing `start`. It raises `dataDone` only two cycles after it observes `descStart`, and it holds `devErr` steady for the whole packet. The single deliberate violation is a second `start` during a packet, which R1 requires to be ignored.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_REGS,
    ST_DATA,
    ST_RESP
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capCtl;
    logic capNextLo;
    logic capNextHi;
    logic capDescLo;
    logic capDescHi;
    logic issue;
    logic kickData;
  } dpStrobe_t;

  localparam int TF_AW     = 5;
  localparam int HDR_WORDS = 8;   // 16 header bytes
  localparam int HDR_LAST  = 5;   // last header word holding information
  localparam int FLAG_VALID = 0;
  localparam int FLAG_DATA  = 2;
  localparam int FLAG_IRQ   = 3;
  localparam int ADDR_SKIP  = 5;
  localparam int ADDR_LAST  = 7;
  localparam logic [7:0] RESP_DONE = 8'h01;
  localparam logic [7:0] RESP_FMT  = 8'h02;
  localparam logic [7:0] RESP_DEV  = 8'h08;

endpackage

// File: rtl/pkt_seq_datapath.sv
module pkt_seq_datapath
  import pkt_seq_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  localparam int BUF_WORDS = BUF_BYTES / 2,
  localparam int WW = $clog2(BUF_WORDS),
  localparam int LW = WW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [15:0]       bufData,
  output logic              flagValid,
  output logic              flagData,
  output logic              flagIrq,
  output logic [LW-1:0]     pairLimit,
  output logic              tfWe,
  output logic [TF_AW-1:0]  tfAddr,
  output logic [7:0]        tfData,
  output logic              descStart,
  output logic [31:0]       descPtr,
  output logic [31:0]       nextPtr
);

  logic [7:0]  lenField;
  logic [10:0] rawLim;

  assign rawLim = 11'(HDR_WORDS) + {1'b0, lenField, 2'b00};

  always_comb begin
    if (rawLim > 11'(BUF_WORDS)) pairLimit = LW'(BUF_WORDS);
    else                         pairLimit = LW'(rawLim);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagValid <= 1'b0;
      flagData  <= 1'b0;
      flagIrq   <= 1'b0;
      lenField  <= '0;
      nextPtr   <= '0;
      descPtr   <= '0;
      tfWe      <= 1'b0;
      tfAddr    <= '0;
      tfData    <= '0;
      descStart <= 1'b0;
    end else begin
      if (strobe.capCtl) begin
        flagValid <= bufData[FLAG_VALID];
        flagData  <= bufData[FLAG_DATA];
        flagIrq   <= bufData[FLAG_IRQ];
        lenField  <= bufData[15:8];
      end
      if (strobe.capNextLo) nextPtr[15:0]  <= bufData;
      if (strobe.capNextHi) nextPtr[31:16] <= bufData;
      if (strobe.capDescLo) descPtr[15:0]  <= bufData;
      if (strobe.capDescHi) descPtr[31:16] <= bufData;
      tfWe <= strobe.issue & ~bufData[8 + ADDR_SKIP];
      if (strobe.issue) begin
        tfAddr <= bufData[8 +: TF_AW];
        tfData <= bufData[7:0];
      end
      descStart <= strobe.kickData;
    end
  end

  assert_desc_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    descStart |=> !descStart);

  assert_write_from_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    tfWe |-> $past(strobe.issue) && !$past(bufData[8 + ADDR_SKIP]));

endmodule

// File: rtl/pkt_seq_ctrl.sv
module pkt_seq_ctrl
  import pkt_seq_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  localparam int BUF_WORDS = BUF_BYTES / 2,
  localparam int WW = $clog2(BUF_WORDS),
  localparam int LW = WW + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           dataDone,
  input  logic           devErr,
  input  logic           rdLast,
  input  logic           flagValid,
  input  logic           flagData,
  input  logic [LW-1:0]  pairLimit,
  output logic [WW-1:0]  bufAddr,
  output dpStrobe_t      strobe,
  output logic           busy,
  output logic           respWe,
  output logic [7:0]     respByte
);

  seqState_t   state;
  logic [2:0]  hIdx;
  logic [LW-1:0] wIdx;
  logic        fmtErr;
  logic        atLimit;

  assign atLimit  = (wIdx >= pairLimit);
  assign bufAddr  = (state == ST_HDR) ? WW'(hIdx) : wIdx[WW-1:0];
  assign busy     = (state != ST_IDLE);
  assign respWe   = (state == ST_RESP);
  assign respByte = fmtErr ? RESP_FMT : (devErr ? RESP_DEV : RESP_DONE);

  always_comb begin
    strobe = '0;
    if (state == ST_HDR) begin
      strobe.capCtl    = (hIdx == 3'd1);
      strobe.capNextLo = (hIdx == 3'd2);
      strobe.capNextHi = (hIdx == 3'd3);
      strobe.capDescLo = (hIdx == 3'd4);
      strobe.capDescHi = (hIdx == 3'(HDR_LAST));
    end
    if (state == ST_REGS && !atLimit) begin
      strobe.issue    = 1'b1;
      strobe.kickData = rdLast & flagData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hIdx   <= '0;
      wIdx   <= '0;
      fmtErr <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_HDR;
          hIdx   <= 3'd1;
          fmtErr <= 1'b0;
        end
        ST_HDR: begin
          if (hIdx == 3'(HDR_LAST)) begin
            if (!flagValid) begin
              fmtErr <= 1'b1;
              state  <= ST_RESP;
            end else begin
              wIdx  <= LW'(HDR_WORDS);
              state <= ST_REGS;
            end
          end else begin
            hIdx <= hIdx + 3'd1;
          end
        end
        ST_REGS: begin
          if (atLimit) begin
            fmtErr <= 1'b1;
            state  <= ST_RESP;
          end else if (rdLast) begin
            state <= flagData ? ST_DATA : ST_RESP;
          end else begin
            wIdx <= wIdx + LW'(1);
          end
        end
        ST_DATA: if (dataDone) state <= ST_RESP;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_resp_ends_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    respWe |=> !busy && !respWe);

  assert_invalid_is_fmt_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HDR && hIdx == 3'(HDR_LAST) && !flagValid) |=> respWe && respByte == RESP_FMT);

  assert_limit_is_fmt_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REGS && atLimit) |=> respWe && respByte == RESP_FMT);

endmodule

// File: rtl/pkt_reg_sequencer.sv
module pkt_reg_sequencer
  import pkt_seq_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  localparam int BUF_WORDS = BUF_BYTES / 2,
  localparam int WW = $clog2(BUF_WORDS),
  localparam int LW = WW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [WW-1:0]     bufAddr,
  input  logic [15:0]       bufData,
  output logic              tfWe,
  output logic [TF_AW-1:0]  tfAddr,
  output logic [7:0]        tfData,
  output logic              descStart,
  output logic [31:0]       descPtr,
  output logic [31:0]       nextPtr,
  input  logic              dataDone,
  input  logic              devErr,
  output logic              respWe,
  output logic [7:0]        respByte,
  output logic              irq,
  output logic              busy
);

  dpStrobe_t     strobe;
  logic          flagValid;
  logic          flagData;
  logic          flagIrq;
  logic [LW-1:0] pairLimit;

  pkt_seq_ctrl #(.BUF_BYTES(BUF_BYTES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .dataDone  (dataDone),
    .devErr    (devErr),
    .rdLast    (bufData[8 + ADDR_LAST]),
    .flagValid (flagValid),
    .flagData  (flagData),
    .pairLimit (pairLimit),
    .bufAddr   (bufAddr),
    .strobe    (strobe),
    .busy      (busy),
    .respWe    (respWe),
    .respByte  (respByte)
  );

  pkt_seq_datapath #(.BUF_BYTES(BUF_BYTES)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bufData   (bufData),
    .flagValid (flagValid),
    .flagData  (flagData),
    .flagIrq   (flagIrq),
    .pairLimit (pairLimit),
    .tfWe      (tfWe),
    .tfAddr    (tfAddr),
    .tfData    (tfData),
    .descStart (descStart),
    .descPtr   (descPtr),
    .nextPtr   (nextPtr)
  );

  assign irq = respWe & flagIrq;

  assert_irq_in_resp_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> respWe);

  assert_desc_before_resp_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({descStart, respWe}));

endmodule

// File: tb/sim_pkt_reg_sequencer.sv
module sim_pkt_reg_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_BYTES  = 256;
  localparam int WW         = $clog2(BUF_BYTES / 2);
  localparam int MAX_PAIRS  = (BUF_BYTES - 16) / 2;

  logic clk = 1'b0;
  logic rstN, start, dataDone, devErr;
  logic [WW-1:0] bufAddr;
  logic [15:0] bufData;
  logic tfWe, descStart, respWe, irq, busy;
  logic [4:0] tfAddr;
  logic [7:0] tfData, respByte;
  logic [31:0] descPtr, nextPtr;

  logic [7:0] mem [BUF_BYTES];
  assign bufData = {mem[{bufAddr, 1'b1}], mem[{bufAddr, 1'b0}]};

  pkt_reg_sequencer #(.BUF_BYTES(BUF_BYTES)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .bufAddr(bufAddr), .bufData(bufData),
    .tfWe(tfWe), .tfAddr(tfAddr), .tfData(tfData), .descStart(descStart),
    .descPtr(descPtr), .nextPtr(nextPtr), .dataDone(dataDone), .devErr(devErr),
    .respWe(respWe), .respByte(respByte), .irq(irq), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nRun = 0;
  int nFail = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < BUF_BYTES; i++) mem[i] = 8'h00;
  endtask

  task automatic putHdr(input logic [7:0] fl, input logic [7:0] ln,
                        input logic [31:0] nxt, input logic [31:0] dsc);
    mem[2] = fl; mem[3] = ln;
    for (int b = 0; b < 4; b++) begin
      mem[4 + b] = nxt[8*b +: 8];
      mem[8 + b] = dsc[8*b +: 8];
    end
  endtask

  task automatic putPair(input int p, input logic [7:0] val, input logic [7:0] adr);
    mem[16 + 2*p] = val;
    mem[17 + 2*p] = adr;
  endtask

  function automatic logic [7:0] regIdx(input int sel);
    case (sel % 7)
      0: return 8'h0E;
      1: return 8'h12;
      2: return 8'h13;
      3: return 8'h14;
      4: return 8'h15;
      5: return 8'h16;
      default: return 8'h17;
    endcase
  endfunction

  logic [4:0] expA [MAX_PAIRS];
  logic [7:0] expD [MAX_PAIRS];
  int         expC [MAX_PAIRS];
  logic [4:0] gotA [MAX_PAIRS];
  logic [7:0] gotD [MAX_PAIRS];
  int         gotC [MAX_PAIRS];

  task automatic runPkt(input string tag, input logic devE, input int extraStart);
    logic [7:0] fl, ln, a, expResp;
    int limit, expN, lat, p, gotN, descCyc, respCyc, nDesc, busyBad;
    bit fmt, wantDesc;
    logic [31:0] expNext, expDesc, gotDesc;
    logic [7:0] gotResp;
    logic gotIrq;
    fl = mem[2]; ln = mem[3];
    limit = 4 * int'(ln);
    if (limit > MAX_PAIRS) limit = MAX_PAIRS;
    expN = 0; fmt = 0; wantDesc = 0; lat = 0; p = 0;
    expNext = {mem[7], mem[6], mem[5], mem[4]};
    expDesc = {mem[11], mem[10], mem[9], mem[8]};
    if (!fl[0]) begin
      fmt = 1; lat = 5;
    end else begin
      while (1) begin
        if (p >= limit) begin fmt = 1; lat = 6 + p; break; end
        a = mem[17 + 2*p];
        if (!a[5]) begin
          expA[expN] = a[4:0]; expD[expN] = mem[16 + 2*p]; expC[expN] = 6 + p; expN++;
        end
        if (a[7]) begin
          wantDesc = fl[2];
          lat = fl[2] ? (5 + p + 1 + 3) : (5 + p + 1);
          break;
        end
        p++;
      end
    end
    expResp = fmt ? 8'h02 : (devE ? 8'h08 : 8'h01);

    gotN = 0; descCyc = -1; respCyc = -1; nDesc = 0; busyBad = 0;
    gotDesc = '0; gotResp = '0; gotIrq = 1'b0;
    @(negedge clk);
    start = 1'b1; devErr = devE;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 1; k <= 400 && respCyc < 0; k++) begin
      @(posedge clk); #1;
      dataDone = (descCyc >= 0 && k == descCyc + 2);
      start = (k == extraStart);
      if (busy !== 1'b1) busyBad++;
      if (tfWe) begin
        if (gotN < MAX_PAIRS) begin
          gotA[gotN] = tfAddr; gotD[gotN] = tfData; gotC[gotN] = k;
        end
        gotN++;
      end
      if (descStart) begin nDesc++; descCyc = k; gotDesc = descPtr; end
      if (respWe) begin respCyc = k; gotResp = respByte; gotIrq = irq; end
    end
    start = 1'b0; dataDone = 1'b0;
    if (respCyc < 0) $display("FAIL R9 %s: no response (actual none expected cycle %0d)", tag, lat);
    check("R1", {tag, " busy high while active"}, busyBad, 0);
    check("R4", {tag, " response cycle"}, respCyc, lat);
    check("R9", {tag, " response byte"}, gotResp, expResp);
    check("R10", {tag, " irq"}, gotIrq, fl[3]);
    check("R5", {tag, " write count"}, gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) begin
      check("R4", {tag, " write addr"}, gotA[i], expA[i]);
      check("R4", {tag, " write data"}, gotD[i], expD[i]);
      check("R6", {tag, " write cycle"}, gotC[i], expC[i]);
    end
    check("R8", {tag, " descStart pulses"}, nDesc, wantDesc);
    if (wantDesc) check("R2", {tag, " descPtr"}, gotDesc, expDesc);
    if (fl[0]) check("R2", {tag, " nextPtr"}, nextPtr, expNext);
    @(posedge clk); #1;
    check("R1", {tag, " busy low after response"}, busy, 0);
    if (extraStart > 0) begin
      int extra = 0;
      for (int k = 0; k < 20; k++) begin
        @(posedge clk); #1;
        if (respWe || tfWe || busy) extra++;
      end
      check("R1", {tag, " start while busy ignored"}, extra, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; dataDone = 1'b0; devErr = 1'b0;
    clearMem();
    repeat (4) @(posedge clk);
    #1;
    check("R1", "reset busy", busy, 0);
    check("R4", "reset tfWe", tfWe, 0);
    check("R9", "reset respWe", respWe, 0);
    check("R8", "reset descStart", descStart, 0);
    check("R10", "reset irq", irq, 0);
    @(negedge clk); rstN = 1'b1;

    // 28-bit command with data phase and interrupt
    clearMem();
    putHdr(8'h0D, 8'd2, 32'h1234_5678, 32'hCAFE_0040);
    putPair(0, 8'hE0, 8'h16); putPair(1, 8'h08, 8'h12); putPair(2, 8'h11, 8'h13);
    putPair(3, 8'h22, 8'h14); putPair(4, 8'h33, 8'h15); putPair(5, 8'h00, 8'h0E);
    putPair(6, 8'h20, 8'h20); putPair(7, 8'hC8, 8'h97);
    runPkt("lba28", 1'b0, 0);

    // 48-bit command: high bytes before low bytes
    clearMem();
    putHdr(8'h05, 8'd3, 32'hA5A5_0001, 32'h0000_8000);
    putPair(0, 8'h40, 8'h16);
    putPair(1, 8'h01, 8'h12); putPair(2, 8'h02, 8'h13); putPair(3, 8'h03, 8'h14); putPair(4, 8'h04, 8'h15);
    putPair(5, 8'h10, 8'h12); putPair(6, 8'h20, 8'h13); putPair(7, 8'h30, 8'h14); putPair(8, 8'h50, 8'h15);
    putPair(9, 8'h00, 8'h0E); putPair(10, 8'h20, 8'h20); putPair(11, 8'h25, 8'h97);
    runPkt("lba48", 1'b0, 0);

    // R3 invalid packet
    clearMem();
    putHdr(8'h0C, 8'd2, 32'h1, 32'h2);
    putPair(0, 8'hE0, 8'h16); putPair(1, 8'hC8, 8'h97);
    runPkt("R3 invalid", 1'b0, 0);

    // R7 zero length
    clearMem();
    putHdr(8'h01, 8'd0, 32'h3, 32'h4);
    putPair(0, 8'hE0, 8'h96);
    runPkt("R7 zero length", 1'b0, 0);

    // R7 overrun for small lengths
    for (int ln = 1; ln <= 3; ln++) begin
      clearMem();
      putHdr(8'h09, 8'(ln), 32'h10 + 32'(ln), 32'h20);
      for (int p = 0; p < 4 * ln + 2; p++)
        putPair(p, 8'(p * 5 + ln), (p % 3 == 1) ? 8'h32 : 8'h12);
      runPkt("R7 overrun", 1'b0, 0);
    end

    // R7 limit capped by buffer
    clearMem();
    putHdr(8'h01, 8'd255, 32'h5, 32'h6);
    for (int p = 0; p < MAX_PAIRS; p++) putPair(p, 8'(p), 8'h13);
    runPkt("R7 buffer cap", 1'b0, 0);

    // R9 device error, no data phase
    clearMem();
    putHdr(8'h09, 8'd1, 32'h7, 32'h8);
    putPair(0, 8'hE0, 8'h16); putPair(1, 8'hEC, 8'h97);
    runPkt("R9 device error", 1'b1, 0);

    // R1 second start during a packet
    clearMem();
    putHdr(8'h05, 8'd1, 32'h9, 32'hA);
    putPair(0, 8'h01, 8'h12); putPair(1, 8'h02, 8'h13); putPair(2, 8'hC8, 8'h97);
    runPkt("R1 start while busy", 1'b0, 3);

    // sweep over list lengths, skip patterns, flags and device error
    for (int n = 1; n <= 24; n++) begin
      logic [7:0] fl;
      logic [7:0] ad;
      clearMem();
      fl = 8'h01 | ((n % 3 == 0) ? 8'h04 : 8'h00) | ((n % 2 == 1) ? 8'h08 : 8'h00);
      putHdr(fl, 8'((2 * n + 7) / 8), 32'h100 * 32'(n), 32'hBEEF_0000 + 32'(n));
      for (int p = 0; p < n; p++) begin
        ad = regIdx(p + n);
        if ((p * 3 + n) % 5 == 0) ad = ad | 8'h20;
        if (p == n - 1) begin
          ad = ad | 8'h80;
          if (n % 4 == 2) ad = ad | 8'h20;
        end
        putPair(p, 8'(n * 7 + p * 13), ad);
      end
      runPkt("sweep R5 R6", (n % 4 == 0), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule